// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block sequences the drive of a passive, time-multiplexed segment display of up to 8 common lines and 44 segment lines. Each output pin carries a small voltage-level index; an analog stage outside this block turns that index into a real voltage. The selected duty sets how many commons take turns. The selected bias sets the top level index. The sign of every drive is mirrored on alternate frames, so each pixel sees zero average voltage.

Pixel data is written row by row into a shadow store. A request moves the whole shadow into the displayed store, but only where one frame ends and the next begins, so a half-written picture is never shown. A done flag then reports that the copy took place. Up to eight pixels, each chosen by a common and a segment index, can be made to flash at a rate counted in frames. Any common or segment pin can be released for other use. A released pin has its drive enable held low.

Top module: `segLcdTop`

## Requirements
- R1: A time slot lasts 2^prescSel × (divVal+1) clock cycles. The slots run 0,1,…,N−1 and then wrap, and common k is the selected one during slot k. After enable rises, the first slot change happens at the end of the first full slot period.
- R2: dutySel codes 0,1,2,3,4 select N = 1,2,3,4,8 commons; any other code also gives 8. Commons with index ≥ N have comOe low and level 0.
- R3: The top level is T = biasSel+1. In a non-inverted frame the selected common is at T and the unselected driven commons are at 1 (0 when T = 1). Exactly one driven common is at the selected level.
- R4: The phase flips at every frame end, which is the close of slot N−1. An inverted frame drives every common and segment level x as T−x. The first frame after enable is non-inverted.
- R5: A lit pixel's segment takes the level of an unselected segment's complement of the selected common: 0 in a non-inverted frame. An unlit segment takes T−1, or T when T = 1. Both follow the inversion rule of R4.
- R6: A row write (ramWrEn, ramWrCom, ramWrData; bit j is segment j) goes to the shadow store only. It has no effect on the outputs until a copy happens.
- R7: After a cycle with updReq high, the shadow store is copied to the displayed store at the next frame end. updDone rises on that same clock edge.
- R8: A cycle with updReq high makes updDone low on the next cycle.
- R9: Each blink entry k has mask bit k, common field k (3 bits at k×3) and segment field k (6 bits at k×6). While the blink phase is off, enabled entries force their pixel unlit. The phase toggles at every (blinkDiv+1)-th frame end after blinkEn rises. Entries whose mask bit is clear have no effect.
- R10: A common or segment pin whose enable bit (comPinEn / segPinEn) is low has its output enable low and its level 0.
- R11: While enable is low or reset is active, all output enables and levels are 0. The slot, the phase and the blink state are also cleared. After reset updDone is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the sequencer; low clears timing state |
| dutySel | input | 3 | Duty code: number of commons |
| biasSel | input | 2 | Bias code: top level T = biasSel+1 |
| prescSel | input | 3 | Prescaler exponent |
| divVal | input | 8 | Divider count minus one |
| ramWrEn | input | 1 | Shadow row write strobe |
| ramWrCom | input | 3 | Row (common) being written |
| ramWrData | input | 44 | Row contents, bit j = segment j |
| updReq | input | 1 | Request a shadow-to-display copy |
| blinkEn | input | 1 | Enables blinking |
| blinkDiv | input | 4 | Frames per blink phase minus one |
| blinkMask | input | 8 | Enable per blink entry |
| blinkCom | input | 24 | Common index per blink entry, 3 bits each |
| blinkSeg | input | 48 | Segment index per blink entry, 6 bits each |
| comPinEn | input | 8 | Common pins kept for display use |
| segPinEn | input | 44 | Segment pins kept for display use |
| comOe | output | 8 | Drive enable per common |
| segOe | output | 44 | Drive enable per segment |
| comLvl | output | 24 | Level index per common, 3 bits each |
| segLvl | output | 132 | Level index per segment, 3 bits each |
| updDone | output | 1 | Copy completed since last request |

## Verification
The bench builds the block with its defaults: 8 commons, 44 segments, 3-bit levels and 8 blink entries. This lets every duty code, including the eight-common one, and every bias from static to quarter run at full width. It varies prescSel and divVal (slot periods of 2, 4 and 6 clocks), so the prescaler and the divider each move the slot timing on their own. Short slots keep whole multi-frame sequences for the update handshake and the blink phase within a few dozen cycles, so the exact frame-end edges can be predicted.

// File: rtl/segLcdPkg.sv
package segLcdPkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic slotTick;
    logic frameEnd;
    logic copy;
  } lcdStrobe_t;

  // Number of commons in use for a duty code
  function automatic logic [3:0] dutyToCommons(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/segLcdCtrl.sv
module segLcdCtrl
  import segLcdPkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int PSEL_W  = 3,
  parameter int DIV_W   = 8,
  parameter int BLINK_W = 4,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int CN_W   = COM_W + 1,
  localparam int PCNT_W = (1 << PSEL_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [2:0]         dutySel,
  input  logic [PSEL_W-1:0]  prescSel,
  input  logic [DIV_W-1:0]   divVal,
  input  logic               updReq,
  input  logic               blinkEn,
  input  logic [BLINK_W-1:0] blinkDiv,
  output logic [COM_W-1:0]   slot,
  output logic [CN_W-1:0]    nCom,
  output logic               invPhase,
  output logic               blinkOff,
  output logic               updDone,
  output lcdStrobe_t         stb
);

  logic [PCNT_W-1:0]  pCnt;
  logic [PCNT_W-1:0]  pLimit;
  logic [DIV_W-1:0]   dCnt;
  logic [BLINK_W-1:0] bCnt;
  logic               pTick;
  logic               lastSlot;
  logic               pending;
  logic [3:0]         dutyCom;

  always_comb begin
    dutyCom = dutyToCommons(dutySel);
    if (32'(dutyCom) > NUM_COM) nCom = CN_W'(NUM_COM);
    else                        nCom = CN_W'(dutyCom);
  end

  assign pLimit       = ~({PCNT_W{1'b1}} << prescSel);
  assign pTick        = (pCnt == pLimit);
  assign stb.slotTick = pTick && (dCnt == divVal);
  assign lastSlot     = ({1'b0, slot} >= (nCom - CN_W'(1)));
  assign stb.frameEnd = stb.slotTick && lastSlot;
  assign stb.copy     = stb.frameEnd && pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pCnt     <= '0;
      dCnt     <= '0;
      slot     <= '0;
      invPhase <= 1'b0;
      bCnt     <= '0;
      blinkOff <= 1'b0;
    end else if (!enable) begin
      pCnt     <= '0;
      dCnt     <= '0;
      slot     <= '0;
      invPhase <= 1'b0;
      bCnt     <= '0;
      blinkOff <= 1'b0;
    end else begin
      pCnt <= pTick ? '0 : pCnt + PCNT_W'(1);
      if (pTick) dCnt <= stb.slotTick ? '0 : dCnt + DIV_W'(1);
      if (stb.slotTick) slot <= lastSlot ? '0 : slot + COM_W'(1);
      if (stb.frameEnd) invPhase <= ~invPhase;
      if (!blinkEn) begin
        bCnt     <= '0;
        blinkOff <= 1'b0;
      end else if (stb.frameEnd) begin
        if (bCnt == blinkDiv) begin
          bCnt     <= '0;
          blinkOff <= ~blinkOff;
        end else begin
          bCnt <= bCnt + BLINK_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      updDone <= 1'b0;
    end else if (updReq) begin
      pending <= 1'b1;
      updDone <= 1'b0;
    end else if (stb.copy) begin
      pending <= 1'b0;
      updDone <= 1'b1;
    end
  end

endmodule

// File: rtl/segLcdData.sv
module segLcdData
  import segLcdPkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 44,
  parameter int LVL_W   = 3,
  parameter int BLINK_N = 8,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int CN_W   = COM_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [1:0]               biasSel,
  input  lcdStrobe_t               stb,
  input  logic [COM_W-1:0]         slot,
  input  logic [CN_W-1:0]          nCom,
  input  logic                     invPhase,
  input  logic                     blinkOff,
  input  logic                     ramWrEn,
  input  logic [COM_W-1:0]         ramWrCom,
  input  logic [NUM_SEG-1:0]       ramWrData,
  input  logic [BLINK_N-1:0]       blinkMask,
  input  logic [BLINK_N*COM_W-1:0] blinkCom,
  input  logic [BLINK_N*SEG_W-1:0] blinkSeg,
  input  logic [NUM_COM-1:0]       comPinEn,
  input  logic [NUM_SEG-1:0]       segPinEn,
  output logic [NUM_COM-1:0]       comOe,
  output logic [NUM_SEG-1:0]       segOe,
  output logic [NUM_COM*LVL_W-1:0] comLvl,
  output logic [NUM_SEG*LVL_W-1:0] segLvl
);

  logic [NUM_SEG-1:0] shadowRam [NUM_COM];
  logic [NUM_SEG-1:0] activeRam [NUM_COM];
  logic [NUM_SEG-1:0] blinkHit;
  logic [NUM_SEG-1:0] pixOn;
  logic [LVL_W-1:0]   topLvl, nonRaw, offRaw;
  logic [LVL_W-1:0]   comSelL, comNonL, segOnL, segOffL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_COM; r++) begin
        shadowRam[r] <= '0;
        activeRam[r] <= '0;
      end
    end else begin
      if (ramWrEn) shadowRam[ramWrCom] <= ramWrData;
      if (stb.copy) begin
        for (int r = 0; r < NUM_COM; r++) activeRam[r] <= shadowRam[r];
      end
    end
  end

  always_comb begin
    blinkHit = '0;
    for (int j = 0; j < NUM_SEG; j++) begin
      for (int k = 0; k < BLINK_N; k++) begin
        if (blinkMask[k] && (blinkCom[k*COM_W +: COM_W] == slot) &&
            (blinkSeg[k*SEG_W +: SEG_W] == SEG_W'(j)))
          blinkHit[j] = 1'b1;
      end
    end
  end

  assign pixOn = activeRam[slot] & ~({NUM_SEG{blinkOff}} & blinkHit);

  // Level codes: raw values for the non-inverted frame, mirrored as T-x otherwise
  assign topLvl  = LVL_W'(biasSel) + LVL_W'(1);
  assign nonRaw  = (topLvl > LVL_W'(1)) ? LVL_W'(1) : '0;
  assign offRaw  = (topLvl > LVL_W'(1)) ? topLvl - LVL_W'(1) : topLvl;
  assign comSelL = invPhase ? '0 : topLvl;
  assign comNonL = invPhase ? topLvl - nonRaw : nonRaw;
  assign segOnL  = invPhase ? topLvl : '0;
  assign segOffL = invPhase ? topLvl - offRaw : offRaw;

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign comOe[i] = enable && comPinEn[i] && (CN_W'(i) < nCom);
    assign comLvl[i*LVL_W +: LVL_W] = !comOe[i] ? '0 :
                                      (slot == COM_W'(i)) ? comSelL : comNonL;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign segOe[j] = enable && segPinEn[j];
    assign segLvl[j*LVL_W +: LVL_W] = !segOe[j] ? '0 :
                                      pixOn[j] ? segOnL : segOffL;
  end

endmodule

// File: rtl/segLcdTop.sv
module segLcdTop
  import segLcdPkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 44,
  parameter int LVL_W   = 3,
  parameter int PSEL_W  = 3,
  parameter int DIV_W   = 8,
  parameter int BLINK_N = 8,
  parameter int BLINK_W = 4,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int CN_W   = COM_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [2:0]               dutySel,
  input  logic [1:0]               biasSel,
  input  logic [PSEL_W-1:0]        prescSel,
  input  logic [DIV_W-1:0]         divVal,
  input  logic                     ramWrEn,
  input  logic [COM_W-1:0]         ramWrCom,
  input  logic [NUM_SEG-1:0]       ramWrData,
  input  logic                     updReq,
  input  logic                     blinkEn,
  input  logic [BLINK_W-1:0]       blinkDiv,
  input  logic [BLINK_N-1:0]       blinkMask,
  input  logic [BLINK_N*COM_W-1:0] blinkCom,
  input  logic [BLINK_N*SEG_W-1:0] blinkSeg,
  input  logic [NUM_COM-1:0]       comPinEn,
  input  logic [NUM_SEG-1:0]       segPinEn,
  output logic [NUM_COM-1:0]       comOe,
  output logic [NUM_SEG-1:0]       segOe,
  output logic [NUM_COM*LVL_W-1:0] comLvl,
  output logic [NUM_SEG*LVL_W-1:0] segLvl,
  output logic                     updDone
);

  lcdStrobe_t       stb;
  logic [COM_W-1:0] slot;
  logic [CN_W-1:0]  nCom;
  logic             invPhase;
  logic             blinkOff;

  segLcdCtrl #(
    .NUM_COM(NUM_COM), .PSEL_W(PSEL_W), .DIV_W(DIV_W), .BLINK_W(BLINK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dutySel(dutySel),
    .prescSel(prescSel), .divVal(divVal), .updReq(updReq),
    .blinkEn(blinkEn), .blinkDiv(blinkDiv), .slot(slot), .nCom(nCom),
    .invPhase(invPhase), .blinkOff(blinkOff), .updDone(updDone), .stb(stb)
  );

  segLcdData #(
    .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .LVL_W(LVL_W), .BLINK_N(BLINK_N)
  ) u_data (
    .clk(clk), .rstN(rstN), .enable(enable), .biasSel(biasSel), .stb(stb),
    .slot(slot), .nCom(nCom), .invPhase(invPhase), .blinkOff(blinkOff),
    .ramWrEn(ramWrEn), .ramWrCom(ramWrCom), .ramWrData(ramWrData),
    .blinkMask(blinkMask), .blinkCom(blinkCom), .blinkSeg(blinkSeg),
    .comPinEn(comPinEn), .segPinEn(segPinEn), .comOe(comOe), .segOe(segOe),
    .comLvl(comLvl), .segLvl(segLvl)
  );

endmodule

// File: rtl/segLcdChecker.sv
module segLcdChecker #(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 44,
  parameter int LVL_W   = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     enable,
  input logic [1:0]               biasSel,
  input logic                     updReq,
  input logic                     updDone,
  input logic [NUM_COM-1:0]       comPinEn,
  input logic [NUM_COM-1:0]       comOe,
  input logic [NUM_SEG-1:0]       segOe,
  input logic [NUM_COM*LVL_W-1:0] comLvl,
  input logic                     invPhase,
  input logic                     frameEnd,
  input logic                     copy
);

  logic [LVL_W-1:0]   topLvl;
  logic [NUM_COM-1:0] selVec;

  assign topLvl = LVL_W'(biasSel) + LVL_W'(1);

  always_comb begin
    for (int i = 0; i < NUM_COM; i++)
      selVec[i] = comOe[i] &&
                  (comLvl[i*LVL_W +: LVL_W] == (invPhase ? '0 : topLvl));
  end

  a_r3_one_selected_com: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (&comPinEn)) |-> ($countones(selVec) == 1));

  a_r4_flip_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(invPhase)) |-> $past(frameEnd));

  a_r7_done_after_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updDone) |-> $past(copy));

  a_r8_req_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    updReq |=> !updDone);

  a_r11_idle_outputs_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> ((comOe == '0) && (segOe == '0)));

endmodule

bind segLcdTop segLcdChecker #(
  .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .biasSel(biasSel),
  .updReq(updReq), .updDone(updDone), .comPinEn(comPinEn), .comOe(comOe),
  .segOe(segOe), .comLvl(comLvl), .invPhase(invPhase),
  .frameEnd(stb.frameEnd), .copy(stb.copy)
);

// File: tb/segLcdTop_bench.sv
module segLcdTop_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         enable;
  logic [2:0]   dutySel;
  logic [1:0]   biasSel;
  logic [2:0]   prescSel;
  logic [7:0]   divVal;
  logic         ramWrEn;
  logic [2:0]   ramWrCom;
  logic [43:0]  ramWrData;
  logic         updReq;
  logic         blinkEn;
  logic [3:0]   blinkDiv;
  logic [7:0]   blinkMask;
  logic [23:0]  blinkCom;
  logic [47:0]  blinkSeg;
  logic [7:0]   comPinEn;
  logic [43:0]  segPinEn;
  logic [7:0]   comOe;
  logic [43:0]  segOe;
  logic [23:0]  comLvl;
  logic [131:0] segLvl;
  logic         updDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  segLcdTop u_segLcdTop (
    .clk(clk), .rstN(rstN), .enable(enable), .dutySel(dutySel),
    .biasSel(biasSel), .prescSel(prescSel), .divVal(divVal),
    .ramWrEn(ramWrEn), .ramWrCom(ramWrCom), .ramWrData(ramWrData),
    .updReq(updReq), .blinkEn(blinkEn), .blinkDiv(blinkDiv),
    .blinkMask(blinkMask), .blinkCom(blinkCom), .blinkSeg(blinkSeg),
    .comPinEn(comPinEn), .segPinEn(segPinEn), .comOe(comOe), .segOe(segOe),
    .comLvl(comLvl), .segLvl(segLvl), .updDone(updDone)
  );

  // duty, bias, prescSel, divVal, edges since enable, expected slot, phase, commons
  typedef struct packed {
    logic [2:0]  duty;
    logic [1:0]  bias;
    logic [2:0]  psel;
    logic [7:0]  div;
    logic [15:0] edges;
    logic [3:0]  expSlot;
    logic        expInv;
    logic [3:0]  expN;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd4, 2'd2, 3'd0, 8'd1, 16'd5,  4'd2, 1'b0, 4'd8},
    '{3'd4, 2'd2, 3'd0, 8'd1, 16'd17, 4'd0, 1'b1, 4'd8},
    '{3'd2, 2'd1, 3'd0, 8'd1, 16'd9,  4'd1, 1'b1, 4'd3},
    '{3'd3, 2'd3, 3'd1, 8'd2, 16'd13, 4'd2, 1'b0, 4'd4},
    '{3'd0, 2'd0, 3'd0, 8'd1, 16'd7,  4'd0, 1'b1, 4'd1},
    '{3'd1, 2'd1, 3'd0, 8'd1, 16'd3,  4'd1, 1'b0, 4'd2},
    '{3'd3, 2'd2, 3'd2, 8'd0, 16'd19, 4'd0, 1'b1, 4'd4}
  };

  function automatic logic [2:0] mir(input int t, input bit inv, input int raw);
    return inv ? 3'(t - raw) : 3'(raw);
  endfunction

  function automatic logic [2:0] comSelExp(input int t, input bit inv);
    return mir(t, inv, t);
  endfunction

  function automatic logic [2:0] comNonExp(input int t, input bit inv);
    return mir(t, inv, (t > 1) ? 1 : 0);
  endfunction

  function automatic logic [2:0] segOnExp(input int t, input bit inv);
    return mir(t, inv, 0);
  endfunction

  function automatic logic [2:0] segOffExp(input int t, input bit inv);
    return mir(t, inv, (t > 1) ? t - 1 : t);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    enable = 1'b0;
    step(1);
    enable = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; dutySel = 3'd0; biasSel = 2'd0;
    prescSel = 3'd0; divVal = 8'd1; ramWrEn = 1'b0; ramWrCom = 3'd0;
    ramWrData = '0; updReq = 1'b0; blinkEn = 1'b0; blinkDiv = 4'd0;
    blinkMask = '0; blinkCom = '0; blinkSeg = '0;
    comPinEn = '1; segPinEn = '1;

    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11", "comOe in reset", 192'(comOe), 192'(0));
    check("R11", "segOe in reset", 192'(segOe), 192'(0));
    check("R11", "comLvl in reset", 192'(comLvl), 192'(0));
    check("R11", "updDone in reset", 192'(updDone), 192'(0));
    rstN = 1'b1;
    step(3);
    check("R11", "segLvl while disabled", 192'(segLvl), 192'(0));

    // R1 R2 R3 R4 R5: vector walk over duty, bias and slot timing
    foreach (VECS[v]) begin
      logic [23:0] expCom;
      logic [7:0]  expOe;
      int          t;
      dutySel  = VECS[v].duty;
      biasSel  = VECS[v].bias;
      prescSel = VECS[v].psel;
      divVal   = VECS[v].div;
      restart();
      step(int'(VECS[v].edges));
      t = int'(VECS[v].bias) + 1;
      for (int i = 0; i < 8; i++) begin
        if (i >= int'(VECS[v].expN)) begin
          expOe[i] = 1'b0;
          expCom[i*3 +: 3] = 3'd0;
        end else begin
          expOe[i] = 1'b1;
          expCom[i*3 +: 3] = (i == int'(VECS[v].expSlot)) ?
                             comSelExp(t, VECS[v].expInv) :
                             comNonExp(t, VECS[v].expInv);
        end
      end
      check("R2", $sformatf("comOe vec %0d", v), 192'(comOe), 192'(expOe));
      check("R1/R3/R4", $sformatf("comLvl vec %0d", v), 192'(comLvl), 192'(expCom));
      check("R5", $sformatf("seg0 off level vec %0d", v),
            192'(segLvl[2:0]), 192'(segOffExp(t, VECS[v].expInv)));
    end

    // Directed: two commons, bias 1/3 (T=3), 2-clock slots; frame ends at edges 4,8,12,16
    dutySel = 3'd1; biasSel = 2'd2; prescSel = 3'd0; divVal = 8'd1;
    segPinEn = '1; segPinEn[3] = 1'b0;
    comPinEn = '1; comPinEn[1] = 1'b0;
    restart();
    ramWrEn = 1'b1; ramWrCom = 3'd0;
    ramWrData = '0; ramWrData[0] = 1'b1; ramWrData[5] = 1'b1;
    step(1);                                    // edge 1
    ramWrEn = 1'b0;
    check("R10", "segOe released pin 3", 192'(segOe[3]), 192'(0));
    check("R10", "segLvl released pin 3", 192'(segLvl[11:9]), 192'(0));
    check("R10", "segOe kept pin 2", 192'(segOe[2]), 192'(1));
    check("R10", "comOe released common 1", 192'(comOe[1]), 192'(0));
    step(3);                                    // edge 4: slot0, inverted
    check("R6", "shadow write hidden seg0", 192'(segLvl[2:0]), 192'(segOffExp(3, 1'b1)));
    updReq = 1'b1;
    step(1);                                    // edge 5
    updReq = 1'b0;
    check("R8", "updDone low after request", 192'(updDone), 192'(0));
    step(2);                                    // edge 7
    check("R7", "no copy before frame end", 192'(updDone), 192'(0));
    step(1);                                    // edge 8: copy, slot0, non-inverted
    check("R7", "updDone at frame end", 192'(updDone), 192'(1));
    check("R7", "seg0 lit after copy", 192'(segLvl[2:0]), 192'(segOnExp(3, 1'b0)));
    check("R5", "seg1 unlit", 192'(segLvl[5:3]), 192'(segOffExp(3, 1'b0)));
    check("R7", "seg5 lit after copy", 192'(segLvl[17:15]), 192'(segOnExp(3, 1'b0)));
    step(2);                                    // edge 10: slot1, row 1 empty
    check("R5", "seg0 unlit on slot 1", 192'(segLvl[2:0]), 192'(segOffExp(3, 1'b0)));
    updReq = 1'b1;
    step(1);                                    // edge 11
    updReq = 1'b0;
    check("R8", "second request clears done", 192'(updDone), 192'(0));
    // R9: entry0 -> (com0, seg5) enabled; entry1 -> (com0, seg0) masked off
    blinkEn = 1'b1; blinkDiv = 4'd0;
    blinkMask = 8'b0000_0001;
    blinkCom = '0;
    blinkSeg = '0; blinkSeg[5:0] = 6'd5; blinkSeg[11:6] = 6'd0;
    step(1);                                    // edge 12: blink off, inverted, slot0
    check("R9", "blinked pixel forced unlit", 192'(segLvl[17:15]), 192'(segOffExp(3, 1'b1)));
    check("R9", "masked entry has no effect", 192'(segLvl[2:0]), 192'(segOnExp(3, 1'b1)));
    check("R7", "second copy done", 192'(updDone), 192'(1));
    step(4);                                    // edge 16: blink on, non-inverted, slot0
    check("R9", "blinked pixel back on", 192'(segLvl[17:15]), 192'(segOnExp(3, 1'b0)));

    enable = 1'b0;
    step(1);
    check("R11", "comOe after disable", 192'(comOe), 192'(0));
    check("R11", "segLvl after disable", 192'(segLvl), 192'(0));

    finishRun();
  end

endmodule